// File: doc/BRIEF.md
# Per-Bit Access-Policy Control Register

This block is a single control and status register whose width is set by a parameter (8, 16, 32 or 64 bits). Each bit follows an access policy chosen by parameter masks. A bit can be read-only, write-one-to-clear, reserved, clear-on-read or unimplemented. A separate parameter gives the value the register takes at reset. Software reaches the register through a write strobe and a read strobe. Each strobe carries a per-bit enable mask, so that partial-width accesses touch only the selected bits.

Hardware logic sets the write-one-to-clear status bits through a per-bit set input. It sees the stored value at all times on a dedicated output. Two sticky flags record software misuse:
- a write that tries to change a reserved bit;
- a write that carries a 1 into an unimplemented position.

Both flags stay high until reset or a pulse on the flag-clear input.

Top module: `bitpolicy_reg`

## Requirements
- R1: When `rst_n` is low at a clock edge, the stored value becomes `RESET_VAL`, `rd_data` becomes 0 and both error flags become 0.
- R2: On a write, a bit whose write enable is 0, or which is in `RO_MASK`, `W1C_MASK` or `RSVD_MASK`, keeps its old value. Every other bit takes `wr_data`. The new value is visible on `reg_q` one cycle after the strobe.
- R3: On a write, a `W1C_MASK` bit whose write enable is 1 and whose data is 1 is cleared. A 0 written to such a bit leaves it unchanged.
- R4: One cycle after `rd_en`, `rd_data` equals the stored value before that edge ANDed with `rd_bit_en`. Without `rd_en`, `rd_data` holds its last value.
- R5: On a read, each bit set in both `COR_MASK` and `rd_bit_en` is cleared in storage after its value is returned. A `COR_MASK` bit outside `rd_bit_en` keeps its value.
- R6: A write whose `wr_data` differs from the stored value in any `RSVD_MASK` bit sets `rsvd_err` on the next cycle. The reserved bits keep their value.
- R7: A write with a 1 in any `UNIMP_MASK` bit of `wr_data` sets `unimp_err` on the next cycle.
- R8: A 1 on `hw_set` sets the matching `W1C_MASK` bit of storage on the next edge. This wins over a write-one-to-clear or clear-on-read in the same cycle. `hw_set` bits outside `W1C_MASK` have no effect.
- R9: When a read and a write fall in the same cycle, the write is applied first and clear-on-read then acts on the result. `rd_data` returns the value stored before the edge.
- R10: Both error flags are sticky. A flag drops only on reset, or on a cycle where `flag_clr` is high and no new violation of that kind occurs. A new violation in that cycle keeps the flag high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_data | input | W | Write data |
| wr_bit_en | input | W | Per-bit write enable |
| rd_en | input | 1 | Read strobe |
| rd_bit_en | input | W | Per-bit read enable |
| rd_data | output | W | Registered read data |
| hw_set | input | W | Hardware set for write-one-to-clear bits |
| flag_clr | input | 1 | Clears both sticky error flags |
| reg_q | output | W | Current stored value |
| rsvd_err | output | 1 | Sticky reserved-change flag |
| unimp_err | output | 1 | Sticky unimplemented-write flag |

## Verification
The bench drives a status bit through a set and a clear in the same cycle. A design that lets the clear win would silently lose the event.

It reads and writes in one cycle with clear-on-read bits enabled. A design that ordered the two the other way would return post-write data, or would leave a clear-on-read bit set.

It writes ones to write-one-to-clear bits with their enables low, to catch a clear that ignores the per-bit enable. It also writes ones with a zero change to reserved bits. A flag raised on any reserved 1, rather than on a change, would show up there.

A flag-clear that arrives together with a fresh violation must leave the flag high. A design that let the clear take priority would drop that violation.

// File: rtl/bp_pkg.sv
// Package: shared types for the per-bit access-policy register.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package bp_pkg;

    // Kind of misuse a sticky error flag watches for
    typedef enum logic [0:0] {
        FLAG_RSVD  = 1'b0,   // change of a reserved bit
        FLAG_UNIMP = 1'b1    // a 1 written to an unimplemented bit
    } flag_kind_e;

endpackage

// File: rtl/bp_next_state.sv
// Module: bp_next_state
// Computes the next stored value from the current value and one cycle of
// write, read and hardware-set activity. Order: write merge, then
// write-one-to-clear, then clear-on-read, then hardware set (set wins).
// Assumes: masks are constant parameters; purely combinational.
module bp_next_state #(
    parameter int unsigned    W         = 32,
    parameter logic [W-1:0]   RO_MASK   = '0,
    parameter logic [W-1:0]   W1C_MASK  = '0,
    parameter logic [W-1:0]   RSVD_MASK = '0,
    parameter logic [W-1:0]   COR_MASK  = '0
) (
    input  logic [W-1:0] cur,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic [W-1:0] wr_bit_en,
    input  logic         rd_en,
    input  logic [W-1:0] rd_bit_en,
    input  logic [W-1:0] hw_set,
    output logic [W-1:0] nxt
);

    // Bits that direct write data may never reach
    localparam logic [W-1:0] LOCKED = RO_MASK | W1C_MASK | RSVD_MASK;

    for (genvar b = 0; b < W; b++) begin : g_bit
        logic merged;
        logic after_w1c;
        logic after_cor;

        // Write merge: take data only for enabled, unlocked bits
        always_comb begin
            merged = cur[b];
            if (wr_en && wr_bit_en[b] && !LOCKED[b]) begin
                merged = wr_data[b];
            end
        end

        // Write-one-to-clear on enabled status bits
        always_comb begin
            after_w1c = merged;
            if (wr_en && W1C_MASK[b] && wr_bit_en[b] && wr_data[b]) begin
                after_w1c = 1'b0;
            end
        end

        // Clear-on-read for bits selected by the read enable
        always_comb begin
            after_cor = after_w1c;
            if (rd_en && COR_MASK[b] && rd_bit_en[b]) begin
                after_cor = 1'b0;
            end
        end

        // Hardware set on status bits wins over every clear
        always_comb begin
            nxt[b] = after_cor;
            if (W1C_MASK[b] && hw_set[b]) begin
                nxt[b] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/bp_err_flag.sv
// Module: bp_err_flag
// One sticky error flag. KIND selects what counts as a violation: a changed
// reserved bit, or a 1 written into an unimplemented bit. A new violation
// beats a clear request in the same cycle.
// Assumes: synchronous active-low reset; cur is the value before the edge.
module bp_err_flag
    import bp_pkg::*;
#(
    parameter int unsigned  W    = 32,
    parameter flag_kind_e   KIND = FLAG_RSVD,
    parameter logic [W-1:0] MASK = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic [W-1:0] cur,
    input  logic         clr,
    output logic         flag
);

    logic [W-1:0] probe;
    logic         hit;

    // Pick the vector that reveals misuse for this flag kind
    always_comb begin
        probe = (KIND == FLAG_RSVD) ? (cur ^ wr_data) : wr_data;
        hit   = wr_en && |(probe & MASK);
    end

    // Sticky flag register: set on hit, clear on request otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (hit) begin
            flag <= 1'b1;
        end else if (clr) begin
            flag <= 1'b0;
        end
    end

    logic armed;
    // Enables $past-based checks once a defined cycle exists
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    // R10
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        ($past(flag) && !$past(clr)) |-> flag);

    // R6
    flag_raise_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        $past(hit) |-> flag);

endmodule

// File: rtl/bp_read_port.sv
// Module: bp_read_port
// Registered read path: on a read strobe, captures the stored value before
// the edge masked by the read enables; otherwise holds.
// Assumes: synchronous active-low reset clears the captured data.
module bp_read_port #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rd_en,
    input  logic [W-1:0] rd_bit_en,
    input  logic [W-1:0] cur,
    output logic [W-1:0] rd_data
);

    // Read data register, masked per bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= cur & rd_bit_en;
        end
    end

endmodule

// File: rtl/bitpolicy_reg.sv
// Module: bitpolicy_reg (top)
// A single register whose bits follow per-bit access policies set by
// parameter masks: read-only, write-one-to-clear, reserved, clear-on-read
// and unimplemented. Holds storage, instantiates the next-state logic, the
// read port and two sticky misuse flags.
// Assumes: W is 8, 16, 32 or 64; RO_MASK does not overlap W1C_MASK;
// synchronous active-low reset.
module bitpolicy_reg
    import bp_pkg::*;
#(
    parameter int unsigned  W          = 32,
    parameter logic [W-1:0] RESET_VAL  = 32'h5A5A_A5A5,
    parameter logic [W-1:0] RO_MASK    = 32'h0000_00F0,
    parameter logic [W-1:0] W1C_MASK   = 32'h0000_0F00,
    parameter logic [W-1:0] RSVD_MASK  = 32'hF000_0000,
    parameter logic [W-1:0] COR_MASK   = 32'h000F_0000,
    parameter logic [W-1:0] UNIMP_MASK = 32'h0F00_0000
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic [W-1:0] wr_bit_en,
    input  logic         rd_en,
    input  logic [W-1:0] rd_bit_en,
    output logic [W-1:0] rd_data,
    input  logic [W-1:0] hw_set,
    input  logic         flag_clr,
    output logic [W-1:0] reg_q,
    output logic         rsvd_err,
    output logic         unimp_err
);

    // Bits whose value neither software writes nor hardware set may alter
    localparam logic [W-1:0] FROZEN_RO = RO_MASK & ~COR_MASK & ~W1C_MASK;
    localparam logic [W-1:0] FROZEN_RS = RSVD_MASK & ~COR_MASK & ~W1C_MASK;

    logic [W-1:0] store_q;
    logic [W-1:0] store_d;

    bp_next_state #(
        .W(W), .RO_MASK(RO_MASK), .W1C_MASK(W1C_MASK),
        .RSVD_MASK(RSVD_MASK), .COR_MASK(COR_MASK)
    ) u_next (
        .cur(store_q), .wr_en(wr_en), .wr_data(wr_data), .wr_bit_en(wr_bit_en),
        .rd_en(rd_en), .rd_bit_en(rd_bit_en), .hw_set(hw_set), .nxt(store_d)
    );

    // Storage register, loaded with RESET_VAL on reset
    always_ff @(posedge clk) begin
        if (!rst_n) store_q <= RESET_VAL;
        else        store_q <= store_d;
    end

    assign reg_q = store_q;

    bp_read_port #(.W(W)) u_rd (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_bit_en(rd_bit_en),
        .cur(store_q), .rd_data(rd_data)
    );

    bp_err_flag #(.W(W), .KIND(FLAG_RSVD), .MASK(RSVD_MASK)) u_rsvd_flag (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .cur(store_q), .clr(flag_clr), .flag(rsvd_err)
    );

    bp_err_flag #(.W(W), .KIND(FLAG_UNIMP), .MASK(UNIMP_MASK)) u_unimp_flag (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .cur(store_q), .clr(flag_clr), .flag(unimp_err)
    );

    logic armed;
    // Enables $past-based checks once a defined cycle exists
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    // R2
    ro_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        ((reg_q ^ $past(reg_q)) & FROZEN_RO) == '0);

    // R6
    rsvd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        ((reg_q ^ $past(reg_q)) & FROZEN_RS) == '0);

    // R8
    w1c_rise_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        ((reg_q & ~$past(reg_q)) & W1C_MASK & ~$past(hw_set)) == '0);

    // R4
    rd_mask_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        $past(rd_en) |-> ((rd_data & ~$past(rd_bit_en)) == '0));

    // R5
    cor_clear_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        $past(rd_en) |-> ((reg_q & $past(rd_bit_en) & COR_MASK & ~W1C_MASK) == '0));

endmodule

// File: tb/bitpolicy_reg_tb_top.sv
// Bench for bitpolicy_reg: directed corners plus seeded random traffic,
// compared against a reference model written from the requirements.
module bitpolicy_reg_tb_top;

    localparam int unsigned W = 32;
    localparam logic [W-1:0] RST  = 32'h5A5A_A5A5;
    localparam logic [W-1:0] RO   = 32'h0000_00F0;
    localparam logic [W-1:0] W1C  = 32'h0000_0F00;
    localparam logic [W-1:0] RSV  = 32'hF000_0000;
    localparam logic [W-1:0] COR  = 32'h000F_0000;
    localparam logic [W-1:0] UNI  = 32'h0F00_0000;
    localparam logic [W-1:0] ONES = '1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0, rd_en = 1'b0, flag_clr = 1'b0;
    logic [W-1:0] wr_data = '0, wr_bit_en = '0, rd_bit_en = '0, hw_set = '0;
    logic [W-1:0] rd_data, reg_q;
    logic rsvd_err, unimp_err;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // Reference model state
    logic [W-1:0] m_val, m_rd;
    logic m_rsv, m_uni;

    always #4 clk = ~clk;

    bitpolicy_reg #(
        .W(W), .RESET_VAL(RST), .RO_MASK(RO), .W1C_MASK(W1C),
        .RSVD_MASK(RSV), .COR_MASK(COR), .UNIMP_MASK(UNI)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .wr_bit_en(wr_bit_en), .rd_en(rd_en), .rd_bit_en(rd_bit_en),
        .rd_data(rd_data), .hw_set(hw_set), .flag_clr(flag_clr),
        .reg_q(reg_q), .rsvd_err(rsvd_err), .unimp_err(unimp_err)
    );

    task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Stored value after one cycle, built from R2, R3, R5, R8 and R9
    function automatic logic [W-1:0] model_next(
        logic [W-1:0] old, logic we, logic [W-1:0] wd, logic [W-1:0] wm,
        logic re, logic [W-1:0] rm, logic [W-1:0] hs);
        logic [W-1:0] v, lock;
        v = old;
        if (we) begin
            lock = RO | W1C | RSV | ~wm;
            v = (wd & ~lock) | (old & lock);
            v = v & ~(wd & wm & W1C);
        end
        if (re) v = v & ~(COR & rm);
        v = v | (hs & W1C);
        return v;
    endfunction

    // Apply one cycle of stimulus, then compare every output
    task automatic step(string tag, logic we, logic [W-1:0] wd, logic [W-1:0] wm,
                        logic re, logic [W-1:0] rm, logic [W-1:0] hs, logic fc);
        logic hit_r, hit_u;
        wr_en = we; wr_data = wd; wr_bit_en = wm;
        rd_en = re; rd_bit_en = rm; hw_set = hs; flag_clr = fc;
        hit_r = we && |((m_val ^ wd) & RSV);
        hit_u = we && |(wd & UNI);
        if (re) m_rd = m_val & rm;
        m_val = model_next(m_val, we, wd, wm, re, rm, hs);
        m_rsv = hit_r | (m_rsv & ~fc);
        m_uni = hit_u | (m_uni & ~fc);
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0; flag_clr = 1'b0; hw_set = '0;
        chk({tag, " value"}, reg_q, m_val);
        chk({tag, " rd_data"}, rd_data, m_rd);
        chk({tag, " rsvd_err"}, {31'd0, rsvd_err}, {31'd0, m_rsv});
        chk({tag, " unimp_err"}, {31'd0, unimp_err}, {31'd0, m_uni});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_val = RST; m_rd = '0; m_rsv = 1'b0; m_uni = 1'b0;
        // R1: reset state
        chk("R1 reset value", reg_q, RST);
        chk("R1 reset rd_data", rd_data, '0);
        chk("R1 reset flags", {30'd0, rsvd_err, unimp_err}, '0);

        // R2: full write, then a write with half the enables low
        step("R2 full write", 1'b1, 32'h00FF_FF0F, ONES, 1'b0, '0, '0, 1'b0);
        step("R2 partial enable", 1'b1, 32'h0000_0000, 32'h0000_FFFF, 1'b0, '0, '0, 1'b0);
        // R8: hardware sets status bits; hw_set outside W1C ignored
        step("R8 hw set", 1'b0, '0, '0, 1'b0, '0, 32'h0000_0FFF, 1'b0);
        // R3: ones with enable low leave status; zero data leaves status
        step("R3 w1c enable low", 1'b1, 32'h0000_0F00, 32'hFFFF_F0FF, 1'b0, '0, '0, 1'b0);
        step("R3 w1c write zero", 1'b1, 32'h0000_0000, ONES, 1'b0, '0, '0, 1'b0);
        step("R3 w1c clear two", 1'b1, 32'h0000_0300, ONES, 1'b0, '0, '0, 1'b0);
        chk("R3 status bits", reg_q & W1C, 32'h0000_0C00);
        // R8: set and clear collide on bit 10; set wins
        step("R8 set beats clear", 1'b1, 32'h0000_0C00, ONES, 1'b0, '0, 32'h0000_0400, 1'b0);
        chk("R8 collided bit", reg_q & 32'h0000_0400, 32'h0000_0400);
        // R5: clear-on-read, partial read enable
        step("R5 fill cor", 1'b1, 32'h000F_0000, ONES, 1'b0, '0, '0, 1'b0);
        step("R5 read low half", 1'b0, '0, '0, 1'b1, 32'h0003_FFFF, '0, 1'b0);
        chk("R5 cor kept", reg_q & COR, 32'h000C_0000);
        // R9: read and write together; read returns pre-write value
        step("R9 rw same cycle", 1'b1, 32'h000F_00AB, ONES, 1'b1, ONES, '0, 1'b0);
        // R6: no change in reserved bits raises nothing, then a change does
        step("R6 rsvd same", 1'b1, reg_q & RSV, ONES, 1'b0, '0, '0, 1'b0);
        step("R6 rsvd change", 1'b1, reg_q ^ 32'h1000_0000, ONES, 1'b0, '0, '0, 1'b0);
        chk("R6 rsvd flag", {31'd0, rsvd_err}, 32'd1);
        // R7: unimplemented bit written
        step("R7 unimp write", 1'b1, reg_q | 32'h0100_0000, ONES, 1'b0, '0, '0, 1'b0);
        // R10: flag clear with new violation keeps it; plain clear drops it
        step("R10 clr with hit", 1'b1, reg_q | 32'h0200_0000, ONES, 1'b0, '0, '0, 1'b1);
        chk("R10 unimp kept", {31'd0, unimp_err}, 32'd1);
        step("R10 hold", 1'b0, '0, '0, 1'b0, '0, '0, 1'b0);
        step("R10 plain clear", 1'b0, '0, '0, 1'b0, '0, '0, 1'b1);
        chk("R10 flags dropped", {30'd0, rsvd_err, unimp_err}, '0);

        // Random traffic covering R2 R3 R4 R5 R6 R7 R8 R9 R10
        for (int i = 0; i < 600; i++) begin
            logic [W-1:0] hs;
            hs = ($urandom_range(3) == 0) ? $urandom() : '0;
            step("R2/R3/R4/R5/R8/R9/R10 random",
                 $urandom_range(1) == 1, $urandom(),
                 ($urandom_range(3) == 0) ? ONES : $urandom(),
                 $urandom_range(1) == 1,
                 ($urandom_range(3) == 0) ? ONES : $urandom(),
                 hs, $urandom_range(9) == 0);
        end

        // R1: reset mid-run restores everything
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1 re-reset value", reg_q, RST);
        chk("R1 re-reset rd_data", rd_data, '0);
        chk("R1 re-reset flags", {30'd0, rsvd_err, unimp_err}, '0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule